// File: doc/BRIEF.md
# Dual Snapshot Counter with Byte Readout

This block holds two independent binary up-counters, lane A and lane B, each 16 bits wide by default. Each counter advances on its own count pulse. A single capture pulse copies both live counts into a pair of holding registers at the same edge. Software or a neighbouring block can then read those holding registers one byte at a time over a shared 8-bit bus. Because the copy is taken in one edge, reading the four bytes over several cycles always gives a coherent snapshot, even while the counters keep running.

All three clocks of the counting function are modelled as single-cycle enable pulses in one system-clock domain. The three-state bus is modelled as a data output plus a drive-enable flag. Four active-low byte selects pick the byte. When none is asserted, the drive enable drops and the data lines rest at zero.

Lane A reports when it sits at its all-ones value. Feeding that flag into lane B's count enable, with both lanes pulsed together, makes the pair behave as one 32-bit counter. Lane B then advances on the edge where lane A wraps to zero.

Top module: `dual_snapshot_counter`

## Requirements
- R1: On each cycle with `cnt_a_tick` high, counter A increments by one and wraps from 0xFFFF to 0x0000. Without the tick it keeps its value.
- R2: Counter B increments by one (with wrap) only on a cycle where both `cnt_b_tick` and `cnt_b_en` are high. Otherwise it keeps its value.
- R3: On a cycle with `capture_tick` high, both holding registers load the counter values from before that cycle's count edge. Without a capture they keep their contents.
- R4: `carry_a` is high exactly while counter A holds 0xFFFF. With both ticks pulsed together and `cnt_b_en` tied to `carry_a`, the pair counts as one 32-bit value, A being the low half.
- R5: With `rst` high, at the next edge both counters, both holding registers, `bus_data` and `bus_oe` become zero. This takes priority over ticks and captures.
- R6: `sel_n` is active low. Bit 0 selects the A low byte (A[7:0]), bit 1 the A high byte (A[15:8]), bit 2 the B low byte and bit 3 the B high byte. The selected byte of the holding registers appears on `bus_data` with `bus_oe` high one cycle after the select is applied.
- R7: When several select bits are low, the lowest-numbered bit wins (A low, then A high, then B low, then B high).
- R8: When all four select bits are high, `bus_oe` is low and `bus_data` is zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| cnt_a_tick | input | 1 | Count pulse for counter A |
| cnt_b_tick | input | 1 | Count pulse for counter B |
| cnt_b_en | input | 1 | Count enable for counter B |
| capture_tick | input | 1 | Copies both counts into the holding registers |
| sel_n | input | 4 | Active-low byte selects (A low, A high, B low, B high) |
| carry_a | output | 1 | High while counter A is all ones |
| bus_data | output | 8 | Selected byte, zero when not driven |
| bus_oe | output | 1 | Drive enable of the byte bus |

## Verification
The counters are visible only through captures, so a wrong count or a missed wrap shows as a wrong byte on the bus. It appears on the first capture after the fault, one cycle after that byte is selected. A chained sweep through the whole A range exercises the carry flag every cycle. It also shows a misplaced carry as B's low byte reading off by one right after A wraps. Select patterns cycle through all sixteen codes every cycle, so a mapping, priority or drive-enable fault shows on the next cycle's bus output.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int NLANE         = 2;
  localparam int BYTES_PER_LN  = 2;
  localparam int NSLOT         = NLANE * BYTES_PER_LN;
  localparam int SLOT_IDX_W    = $clog2(NSLOT);

  typedef struct packed {
    logic                  hit;
    logic [SLOT_IDX_W-1:0] idx;
  } slot_pick_t;

  // Lowest-numbered asserted (low) select wins.
  function automatic slot_pick_t pick_slot(input logic [NSLOT-1:0] sel_n);
    slot_pick_t p;
    p.hit = 1'b0;
    p.idx = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (!sel_n[k]) begin
        p.hit = 1'b1;
        p.idx = SLOT_IDX_W'(k);
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/snap_counter.sv
module snap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (tick && en) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/snap_hold.sv
module snap_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/snap_byte_mux.sv
module snap_byte_mux
  import snap_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLOT-1:0]        sel_n,
  input  logic [NSLOT*BYTE_W-1:0] slots,
  output logic [BYTE_W-1:0]       data,
  output logic                    oe
);
  slot_pick_t pick;
  logic [BYTE_W-1:0] byte_nxt;

  always_comb begin
    pick     = pick_slot(sel_n);
    byte_nxt = '0;
    if (pick.hit) begin
      byte_nxt = slots[pick.idx*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      oe   <= 1'b0;
    end else begin
      data <= byte_nxt;
      oe   <= pick.hit;
    end
  end
endmodule

// File: rtl/dual_snapshot_counter.sv
module dual_snapshot_counter
  import snap_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = BYTES_PER_LN * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_a_tick,
  input  logic              cnt_b_tick,
  input  logic              cnt_b_en,
  input  logic              capture_tick,
  input  logic [NSLOT-1:0]  sel_n,
  output logic              carry_a,
  output logic [BYTE_W-1:0] bus_data,
  output logic              bus_oe
);
  logic [NLANE-1:0]        lane_tick;
  logic [NLANE-1:0]        lane_en;
  logic [CNT_W-1:0]        cnt_q  [NLANE];
  logic [CNT_W-1:0]        hold_q [NLANE];
  logic [NSLOT*BYTE_W-1:0] slots;

  assign lane_tick = {cnt_b_tick, cnt_a_tick};
  assign lane_en   = {cnt_b_en, 1'b1};

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    snap_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .tick  (lane_tick[l]),
      .en    (lane_en[l]),
      .count (cnt_q[l])
    );

    snap_hold #(.W(CNT_W)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (capture_tick),
      .d    (cnt_q[l]),
      .q    (hold_q[l])
    );

    for (genvar b = 0; b < BYTES_PER_LN; b++) begin : g_byte
      assign slots[(l*BYTES_PER_LN + b)*BYTE_W +: BYTE_W] =
        hold_q[l][b*BYTE_W +: BYTE_W];
    end
  end

  logic [CNT_W-1:0] cnt_a, cnt_b, hold_a, hold_b;
  assign cnt_a  = cnt_q[0];
  assign cnt_b  = cnt_q[1];
  assign hold_a = hold_q[0];
  assign hold_b = hold_q[1];

  assign carry_a = &cnt_a;

  snap_byte_mux #(.BYTE_W(BYTE_W)) u_mux (
    .clk   (clk),
    .rst   (rst),
    .sel_n (sel_n),
    .slots (slots),
    .data  (bus_data),
    .oe    (bus_oe)
  );
endmodule

// File: rtl/snap_checker.sv
module snap_checker #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_a_tick,
  input logic              cnt_b_tick,
  input logic              cnt_b_en,
  input logic              capture_tick,
  input logic [3:0]        sel_n,
  input logic              carry_a,
  input logic [BYTE_W-1:0] bus_data,
  input logic              bus_oe,
  input logic [CNT_W-1:0]  cnt_a,
  input logic [CNT_W-1:0]  cnt_b,
  input logic [CNT_W-1:0]  hold_a,
  input logic [CNT_W-1:0]  hold_b
);
  assert_a_step_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_a_tick |=> cnt_a == CNT_W'($past(cnt_a) + 1'b1));

  assert_a_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !cnt_a_tick |=> $stable(cnt_a));

  assert_b_gate_R2: assert property (@(posedge clk) disable iff (rst)
    !(cnt_b_tick && cnt_b_en) |=> $stable(cnt_b));

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    capture_tick |=> (hold_a == $past(cnt_a)) && (hold_b == $past(cnt_b)));

  assert_hold_keep_R3: assert property (@(posedge clk) disable iff (rst)
    !capture_tick |=> $stable(hold_a) && $stable(hold_b));

  assert_carry_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_a_tick && carry_a) |=> (cnt_a == '0) && !carry_a);

  assert_clear_R5: assert property (@(posedge clk)
    rst |=> (cnt_a == '0) && (cnt_b == '0) && (hold_a == '0) && (hold_b == '0)
            && !bus_oe && (bus_data == '0));

  assert_a_low_R6: assert property (@(posedge clk) disable iff (rst)
    !sel_n[0] |=> bus_oe && (bus_data == $past(hold_a[BYTE_W-1:0])));

  assert_b_high_only_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_n == 4'b0111) |=> bus_oe && (bus_data == $past(hold_b[CNT_W-1:BYTE_W])));

  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (rst)
    (&sel_n) |=> !bus_oe && (bus_data == '0));
endmodule

bind dual_snapshot_counter snap_checker #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_snap_chk (
  .clk          (clk),
  .rst          (rst),
  .cnt_a_tick   (cnt_a_tick),
  .cnt_b_tick   (cnt_b_tick),
  .cnt_b_en     (cnt_b_en),
  .capture_tick (capture_tick),
  .sel_n        (sel_n),
  .carry_a      (carry_a),
  .bus_data     (bus_data),
  .bus_oe       (bus_oe),
  .cnt_a        (cnt_a),
  .cnt_b        (cnt_b),
  .hold_a       (hold_a),
  .hold_b       (hold_b)
);

// File: tb/dual_snapshot_counter_bench.sv
`timescale 1ns/1ps
module dual_snapshot_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_a_tick = 1'b0, cnt_b_tick = 1'b0, cnt_b_en = 1'b0, capture_tick = 1'b0;
  logic [3:0] sel_n = 4'hF;
  logic       carry_a, bus_oe;
  logic [7:0] bus_data;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [15:0] ma = '0, mb = '0, ha = '0, hb = '0;

  always #2.5 clk = ~clk;

  dual_snapshot_counter u_dual_snapshot_counter (
    .clk(clk), .rst(rst), .cnt_a_tick(cnt_a_tick), .cnt_b_tick(cnt_b_tick),
    .cnt_b_en(cnt_b_en), .capture_tick(capture_tick), .sel_n(sel_n),
    .carry_a(carry_a), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  task automatic cyc(input logic ta, input logic tb, input logic eb, input logic cap,
                     input logic [3:0] sel, input logic rr, input string ph);
    logic [7:0]  exp_d;
    logic        exp_oe;
    logic [31:0] slots;
    string       stag;
    int          nlow;
    cnt_a_tick = ta; cnt_b_tick = tb; cnt_b_en = eb; capture_tick = cap;
    sel_n = sel; rst = rr;
    slots  = {hb, ha};
    exp_d  = '0;
    exp_oe = 1'b0;
    nlow   = 0;
    for (int k = 3; k >= 0; k--) begin
      if (!sel[k]) begin
        exp_d  = slots[k*8 +: 8];
        exp_oe = 1'b1;
        nlow++;
      end
    end
    stag = (nlow == 0) ? "R8" : (nlow > 1) ? "R7" : "R6";
    if (rr) begin
      exp_d = '0; exp_oe = 1'b0; stag = "R5";
      ma = '0; mb = '0; ha = '0; hb = '0;
    end else begin
      if (cap) begin ha = ma; hb = mb; end
      if (ta) ma = ma + 16'd1;
      if (tb && eb) mb = mb + 16'd1;
    end
    @(negedge clk);
    vectors++;
    if (bus_oe !== exp_oe || bus_data !== exp_d) begin
      misses++;
      $display("FAIL %s (phase %s, R3 snapshot) bus oe/data actual %b/%h expected %b/%h",
               stag, ph, bus_oe, bus_data, exp_oe, exp_d);
    end
    vectors++;
    if (carry_a !== (ma == 16'hFFFF)) begin
      misses++;
      $display("FAIL R4 (phase %s) carry_a actual %b expected %b", ph, carry_a, (ma == 16'hFFFF));
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    // R5: reset state, ticks and capture during reset have no effect
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 4'b0000, 1, "R5");
    cyc(0, 0, 0, 1, 4'b1110, 0, "R5");
    cyc(0, 0, 0, 0, 4'b1101, 0, "R5");
    // R4: chained 32-bit sweep across a full wrap of A, every select code in turn
    for (int i = 0; i < 65540; i++)
      cyc(1, 1, (ma == 16'hFFFF), (i % 7 == 0), 4'(i), 0, "R4");
    // read the snapshot right after the wrap: B low byte must be 1
    cyc(0, 0, 0, 1, 4'b1011, 0, "R4");
    cyc(0, 0, 0, 0, 4'b1011, 0, "R4");
    cyc(0, 0, 0, 0, 4'b0111, 0, "R4");
    // R2: B gated by enable, A idle
    for (int i = 0; i < 400; i++)
      cyc(0, (i % 3 != 0), (i % 2 == 0), (i % 5 == 0), 4'(i * 3), 0, "R2");
    // R1: A ticks irregularly, B ticks with enable low
    for (int i = 0; i < 300; i++)
      cyc((i % 2 == 0) || (i % 7 == 3), 1, 0, (i % 4 == 0), 4'(i), 0, "R1");
    // R3: long run without capture, then one capture, then readback
    for (int i = 0; i < 200; i++)
      cyc(1, 1, 1, (i == 150), 4'(i), 0, "R3");
    for (int k = 0; k < 4; k++)
      cyc(1, 1, 1, 0, ~(4'b0001 << k), 0, "R3");
    // R5: clear in mid-run, then confirm zero snapshot
    cyc(1, 1, 1, 1, 4'b0000, 1, "R5");
    cyc(0, 0, 0, 1, 4'b1111, 0, "R5");
    for (int k = 0; k < 4; k++)
      cyc(0, 0, 0, 0, ~(4'b0001 << k), 0, "R5");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule